// File: doc/BRIEF.md
# Dual-Write Integer Register File

This block is the integer register file of an in-order core: 32 entries of 32 bits, two combinational read ports and two write ports that may both fire in the same clock. The result port carries values from the ALU and the multicycle units. When floating-point values are kept in integer registers, floating-point results also use this port. The load port writes data returned by the memory unit.

A small tracker holds one outstanding load: its destination index, its base index and whether it is a post-increment load. A post-increment load updates its base register with the new address through the result port and writes its data through the load port. Normally the address lands one cycle before the data. A stall from an older multicycle operation can push the address write into the same cycle as the data. When base and destination are the same register, the tracker gives the load port priority in that case, so the loaded data is always the final value. Every other same-register collision goes to the result port.

Memory requests are issued and granted in one cycle (`ld_issue`), and the response is valid in the following cycle (`mem_rvalid`, `mem_rdata`).

Top module: `wb_regfile`

## Requirements
- R1: While reset is asserted and after it is released, every register reads zero on both read ports until it is written.
- R2: Both read ports are combinational and independent. A write reaches the read ports only after the clock edge that performs it; a same-cycle write is not forwarded.
- R3: Register index 0 always reads zero. A write to index 0 from either port is discarded.
- R4: When `res_we` is 1, `res_data` is written to register `res_idx` at the clock edge.
- R5: `ld_issue` records one pending load (destination, base, post-increment flag). A `mem_rvalid` in a later cycle writes `mem_rdata` to the recorded destination at that edge and clears the entry. A `mem_rvalid` with no pending entry changes no register.
- R6: When both ports write different registers in the same cycle, both writes take effect.
- R7: When both ports write the same register in the same cycle, the result port wins, unless the pending load is post-increment with base index equal to destination index. This covers plain loads and post-increment loads whose base differs from the destination.
- R8: For a post-increment load with base equal to destination, an address write one cycle before the response is visible for one cycle. The response then replaces it with the loaded data.
- R9: For a post-increment load with base equal to destination, an address write delayed into the response cycle is discarded, and the register holds the loaded data.
- R10: With parameter `FP_IN_INT` set to 1 (default), a result-port write flagged by `res_fp` = 1 is written to the integer register of the same index.
- R11: Once a load response has been accepted, later result-port writes to that register behave as ordinary writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to `clk` |
| rd_a_idx | input | 5 | Read port A index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 5 | Read port B index |
| rd_b_data | output | 32 | Read port B data |
| res_we | input | 1 | Result-port write enable |
| res_fp | input | 1 | Result is a floating-point value held in an integer register |
| res_idx | input | 5 | Result-port destination index |
| res_data | input | 32 | Result-port write data |
| ld_issue | input | 1 | Load request issued and granted this cycle |
| ld_postinc | input | 1 | The issued load is post-increment |
| ld_base_idx | input | 5 | Base register index of the issued load |
| ld_dst_idx | input | 5 | Destination register index of the issued load |
| mem_rvalid | input | 1 | Memory response valid |
| mem_rdata | input | 32 | Memory response data |

## Verification
Every write, from either port, is visible on the read ports one edge after it is driven. Load data therefore appears two edges after `ld_issue`: one edge records the entry and the next writes the data. The bench drives all inputs on the falling edge. It samples the read ports a fraction of a nanosecond later, after the rising edge that should have performed the write. For R2 it also samples before that edge, to confirm that the old value is still visible. The collision cases (R7, R9) keep both write enables high for exactly one cycle, and the result is read at the next falling edge.

// File: rtl/wb_regfile_pkg.sv
package wb_regfile_pkg;

  // Which write port wins when both target one register in one cycle
  typedef enum logic {
    PRIO_RESULT = 1'b0,
    PRIO_LOAD   = 1'b1
  } wr_prio_e;

endpackage

// File: rtl/wb_load_tracker.sv
module wb_load_tracker
  import wb_regfile_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_issue,
  input  logic          ld_postinc,
  input  logic [AW-1:0] ld_base_idx,
  input  logic [AW-1:0] ld_dst_idx,
  input  logic          mem_rvalid,
  output logic          pend_vld,
  output logic          pend_pi,
  output logic [AW-1:0] pend_base,
  output logic [AW-1:0] pend_dst,
  output logic          ld_wr_en,
  output wr_prio_e      clash_prio
);

  typedef struct packed {
    logic          vld;
    logic          pi;
    logic [AW-1:0] base;
    logic [AW-1:0] dst;
  } pend_t;

  pend_t cur_q, nxt_d;
  logic  upd_en;

  // next state: a response retires the entry, a new issue overrides
  always_comb begin
    nxt_d = cur_q;
    if (mem_rvalid) nxt_d.vld = 1'b0;
    if (ld_issue) begin
      nxt_d.vld  = 1'b1;
      nxt_d.pi   = ld_postinc;
      nxt_d.base = ld_base_idx;
      nxt_d.dst  = ld_dst_idx;
    end
  end

  assign upd_en = ld_issue | mem_rvalid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (upd_en) cur_q <= nxt_d;
  end

  assign pend_vld  = cur_q.vld;
  assign pend_pi   = cur_q.pi;
  assign pend_base = cur_q.base;
  assign pend_dst  = cur_q.dst;

  assign ld_wr_en = mem_rvalid & cur_q.vld;

  // the load is younger than any result landing with it: when its base
  // and destination coincide the late address update must lose
  assign clash_prio = (cur_q.vld && cur_q.pi && (cur_q.base == cur_q.dst))
                      ? PRIO_LOAD : PRIO_RESULT;

endmodule

// File: rtl/wb_write_arbiter.sv
module wb_write_arbiter
  import wb_regfile_pkg::*;
#(
  parameter int AW        = 5,
  parameter int XLEN      = 32,
  parameter int FP_IN_INT = 1
) (
  input  logic            res_we,
  input  logic            res_fp,
  input  logic [AW-1:0]   res_idx,
  input  logic [XLEN-1:0] res_data,
  input  logic            ld_wr_en,
  input  logic [AW-1:0]   ld_idx,
  input  logic [XLEN-1:0] ld_data,
  input  wr_prio_e        clash_prio,
  output logic            w0_en,
  output logic [AW-1:0]   w0_idx,
  output logic [XLEN-1:0] w0_data,
  output logic            w1_en,
  output logic [AW-1:0]   w1_idx,
  output logic [XLEN-1:0] w1_data
);

  localparam logic FP_ACCEPT = (FP_IN_INT != 0);

  logic res_live, ld_live, clash;

  always_comb begin
    res_live = res_we & (FP_ACCEPT | ~res_fp) & (res_idx != '0);
    ld_live  = ld_wr_en & (ld_idx != '0);
    clash    = res_live & ld_live & (res_idx == ld_idx);
    w0_en    = res_live;
    w1_en    = ld_live;
    if (clash) begin
      if (clash_prio == PRIO_LOAD) w0_en = 1'b0;
      else                         w1_en = 1'b0;
    end
  end

  assign w0_idx  = res_idx;
  assign w0_data = res_data;
  assign w1_idx  = ld_idx;
  assign w1_data = ld_data;

endmodule

// File: rtl/wb_rf_array.sv
module wb_rf_array #(
  parameter int NREG = 32,
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            w0_en,
  input  logic [AW-1:0]   w0_idx,
  input  logic [XLEN-1:0] w0_data,
  input  logic            w1_en,
  input  logic [AW-1:0]   w1_idx,
  input  logic [XLEN-1:0] w1_data,
  input  logic [AW-1:0]   rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [AW-1:0]   rd_b_idx,
  output logic [XLEN-1:0] rd_b_data
);

  logic [XLEN-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs[i] = '0;
    end else begin : g_store
      logic            hit0, hit1, en;
      logic [XLEN-1:0] nxt;

      // arbiter never enables both ports for one index
      always_comb begin
        hit0 = w0_en && (w0_idx == AW'(i));
        hit1 = w1_en && (w1_idx == AW'(i));
        en   = hit0 | hit1;
        nxt  = hit0 ? w0_data : w1_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  regs[i] <= '0;
        else if (en) regs[i] <= nxt;
      end
    end
  end

  assign rd_a_data = regs[rd_a_idx];
  assign rd_b_data = regs[rd_b_idx];

endmodule

// File: rtl/wb_regfile.sv
module wb_regfile
  import wb_regfile_pkg::*;
#(
  parameter int NREG      = 32,
  parameter int XLEN      = 32,
  parameter int FP_IN_INT = 1,
  localparam int AW       = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [AW-1:0]   rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            res_we,
  input  logic            res_fp,
  input  logic [AW-1:0]   res_idx,
  input  logic [XLEN-1:0] res_data,
  input  logic            ld_issue,
  input  logic            ld_postinc,
  input  logic [AW-1:0]   ld_base_idx,
  input  logic [AW-1:0]   ld_dst_idx,
  input  logic            mem_rvalid,
  input  logic [XLEN-1:0] mem_rdata
);

  logic            pend_vld, pend_pi, ld_wr_en;
  logic [AW-1:0]   pend_base, pend_dst;
  wr_prio_e        clash_prio;
  logic            w0_en, w1_en;
  logic [AW-1:0]   w0_idx, w1_idx;
  logic [XLEN-1:0] w0_data, w1_data;

  wb_load_tracker #(.AW(AW)) u_trk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_issue    (ld_issue),
    .ld_postinc  (ld_postinc),
    .ld_base_idx (ld_base_idx),
    .ld_dst_idx  (ld_dst_idx),
    .mem_rvalid  (mem_rvalid),
    .pend_vld    (pend_vld),
    .pend_pi     (pend_pi),
    .pend_base   (pend_base),
    .pend_dst    (pend_dst),
    .ld_wr_en    (ld_wr_en),
    .clash_prio  (clash_prio)
  );

  wb_write_arbiter #(.AW(AW), .XLEN(XLEN), .FP_IN_INT(FP_IN_INT)) u_arb (
    .res_we     (res_we),
    .res_fp     (res_fp),
    .res_idx    (res_idx),
    .res_data   (res_data),
    .ld_wr_en   (ld_wr_en),
    .ld_idx     (pend_dst),
    .ld_data    (mem_rdata),
    .clash_prio (clash_prio),
    .w0_en      (w0_en),
    .w0_idx     (w0_idx),
    .w0_data    (w0_data),
    .w1_en      (w1_en),
    .w1_idx     (w1_idx),
    .w1_data    (w1_data)
  );

  wb_rf_array #(.NREG(NREG), .XLEN(XLEN), .AW(AW)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .w0_en     (w0_en),
    .w0_idx    (w0_idx),
    .w0_data   (w0_data),
    .w1_en     (w1_en),
    .w1_idx    (w1_idx),
    .w1_data   (w1_data),
    .rd_a_idx  (rd_a_idx),
    .rd_a_data (rd_a_data),
    .rd_b_idx  (rd_b_idx),
    .rd_b_data (rd_b_data)
  );

endmodule

// File: rtl/wb_regfile_chk.sv
module wb_regfile_chk #(
  parameter int NREG      = 32,
  parameter int XLEN      = 32,
  parameter int FP_IN_INT = 1,
  localparam int AW       = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   rd_a_idx,
  input logic [XLEN-1:0] rd_a_data,
  input logic [AW-1:0]   rd_b_idx,
  input logic [XLEN-1:0] rd_b_data,
  input logic            res_we,
  input logic            res_fp,
  input logic [AW-1:0]   res_idx,
  input logic [XLEN-1:0] res_data,
  input logic            ld_issue,
  input logic [AW-1:0]   ld_dst_idx,
  input logic            mem_rvalid,
  input logic [XLEN-1:0] mem_rdata,
  input logic            pend_vld,
  input logic            pend_pi,
  input logic [AW-1:0]   pend_base,
  input logic [AW-1:0]   pend_dst
);

  localparam logic FP_OK = (FP_IN_INT != 0);

  // R3: index zero reads zero on both ports
  a_r3_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == '0) |-> (rd_a_data == '0));
  a_r3_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == '0) |-> (rd_b_data == '0));

  // R4: an uncontested result write is visible after the edge
  a_r4_result_write: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && (FP_OK || !res_fp) && (res_idx != '0) && !(mem_rvalid && pend_vld))
    |=> ((rd_a_idx != $past(res_idx)) || (rd_a_data == $past(res_data))));

  // R5: issue records the destination, a lone response retires the entry
  a_r5_issue: assert property (@(posedge clk) disable iff (!rst_n)
    ld_issue |=> (pend_vld && (pend_dst == $past(ld_dst_idx))));
  a_r5_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rvalid && !ld_issue) |=> !pend_vld);

  // R7: ordinary collisions resolve to the result port
  a_r7_result_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && (FP_OK || !res_fp) && (res_idx != '0) && mem_rvalid && pend_vld &&
     (res_idx == pend_dst) && !(pend_pi && (pend_base == pend_dst)))
    |=> ((rd_a_idx != $past(res_idx)) || (rd_a_data == $past(res_data))));

  // R9: post-increment with base equal to destination keeps the load data
  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rvalid && pend_vld && pend_pi && (pend_base == pend_dst) && (pend_dst != '0))
    |=> ((rd_b_idx != $past(pend_dst)) || (rd_b_data == $past(mem_rdata))));

endmodule

bind wb_regfile wb_regfile_chk #(.NREG(NREG), .XLEN(XLEN), .FP_IN_INT(FP_IN_INT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_a_idx   (rd_a_idx),
  .rd_a_data  (rd_a_data),
  .rd_b_idx   (rd_b_idx),
  .rd_b_data  (rd_b_data),
  .res_we     (res_we),
  .res_fp     (res_fp),
  .res_idx    (res_idx),
  .res_data   (res_data),
  .ld_issue   (ld_issue),
  .ld_dst_idx (ld_dst_idx),
  .mem_rvalid (mem_rvalid),
  .mem_rdata  (mem_rdata),
  .pend_vld   (pend_vld),
  .pend_pi    (pend_pi),
  .pend_base  (pend_base),
  .pend_dst   (pend_dst)
);

// File: tb/wb_regfile_bench.sv
`timescale 1ns/100ps
module wb_regfile_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  rd_a_idx, rd_b_idx, res_idx, ld_base_idx, ld_dst_idx;
  logic [31:0] rd_a_data, rd_b_data, res_data, mem_rdata;
  logic        res_we, res_fp, ld_issue, ld_postinc, mem_rvalid;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  logic [31:0] model [32];

  always #2.5 clk = ~clk;

  wb_regfile u_wb_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .res_we(res_we), .res_fp(res_fp), .res_idx(res_idx), .res_data(res_data),
    .ld_issue(ld_issue), .ld_postinc(ld_postinc),
    .ld_base_idx(ld_base_idx), .ld_dst_idx(ld_dst_idx),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // {index, data}: result-port writes, index 0 must stay zero
  localparam logic [36:0] VEC [8] = '{
    {5'd1,  32'h0000_0001}, {5'd2,  32'hFFFF_FFFF}, {5'd0,  32'hBAD0_0000},
    {5'd31, 32'h8000_0000}, {5'd16, 32'h1234_5678}, {5'd3,  32'hA5A5_A5A5},
    {5'd1,  32'h5A5A_5A5A}, {5'd17, 32'h0F0F_0F0F}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    res_we = 0; res_fp = 0; res_idx = '0; res_data = '0;
    ld_issue = 0; ld_postinc = 0; ld_base_idx = '0; ld_dst_idx = '0;
    mem_rvalid = 0; mem_rdata = '0;
  endtask

  task automatic rd_a(input string tag, input int idx);
    rd_a_idx = 5'(idx);
    #0.1;
    chk(tag, rd_a_data, model[idx]);
  endtask

  task automatic rd_b(input string tag, input int idx);
    rd_b_idx = 5'(idx);
    #0.1;
    chk(tag, rd_b_data, model[idx]);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    idle();
    rd_a_idx = '0; rd_b_idx = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rd_b("R1 reset port B", 9);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 32; i++) rd_a("R1 reset state", i);

    // table walk: R2 no bypass before the edge, R4 / R3 after it
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      res_we = 1; res_idx = VEC[v][36:32]; res_data = VEC[v][31:0];
      rd_a("R2 no same-cycle bypass", int'(VEC[v][36:32]));
      @(negedge clk);
      idle();
      if (VEC[v][36:32] != 5'd0) model[VEC[v][36:32]] = VEC[v][31:0];
      rd_a("R4 result write port A", int'(VEC[v][36:32]));
      rd_b("R3 R4 result write port B", int'(VEC[v][36:32]));
    end
    rd_a("R2 port A independent", 2);
    rd_b("R2 port B independent", 31);

    // R6 / R5: plain load and a result write to another register together
    @(negedge clk);
    ld_issue = 1; ld_postinc = 0; ld_base_idx = 5'd5; ld_dst_idx = 5'd6;
    @(negedge clk);
    idle();
    mem_rvalid = 1; mem_rdata = 32'h0000_6666;
    res_we = 1; res_idx = 5'd7; res_data = 32'h0000_7777;
    rd_a("R5 load not written before response edge", 6);
    @(negedge clk);
    idle();
    model[6] = 32'h0000_6666; model[7] = 32'h0000_7777;
    rd_a("R5 R6 load port write", 6);
    rd_b("R6 result port write", 7);

    // R7: plain load collides with result write, result wins
    @(negedge clk);
    ld_issue = 1; ld_postinc = 0; ld_base_idx = 5'd8; ld_dst_idx = 5'd8;
    @(negedge clk);
    idle();
    mem_rvalid = 1; mem_rdata = 32'hDDDD_0008;
    res_we = 1; res_idx = 5'd8; res_data = 32'hAAAA_0008;
    @(negedge clk);
    idle();
    model[8] = 32'hAAAA_0008;
    rd_a("R7 plain load collision", 8);

    // R7: post-increment, base differs from destination, result wins
    @(negedge clk);
    ld_issue = 1; ld_postinc = 1; ld_base_idx = 5'd9; ld_dst_idx = 5'd10;
    @(negedge clk);
    idle();
    mem_rvalid = 1; mem_rdata = 32'hDDDD_0010;
    res_we = 1; res_idx = 5'd10; res_data = 32'hAAAA_0010;
    @(negedge clk);
    idle();
    model[10] = 32'hAAAA_0010;
    rd_b("R7 postinc base!=dst collision", 10);

    // R8: address update one cycle ahead of the data
    @(negedge clk);
    ld_issue = 1; ld_postinc = 1; ld_base_idx = 5'd11; ld_dst_idx = 5'd11;
    res_we = 1; res_idx = 5'd11; res_data = 32'h0000_1004;
    @(negedge clk);
    idle();
    model[11] = 32'h0000_1004;
    rd_a("R8 address visible first", 11);
    mem_rvalid = 1; mem_rdata = 32'h0000_CAFE;
    @(negedge clk);
    idle();
    model[11] = 32'h0000_CAFE;
    rd_a("R8 load data final", 11);

    // R9: stall pushes the address update into the response cycle
    @(negedge clk);
    res_we = 1; res_idx = 5'd16; res_data = 32'h0000_0DD0;
    @(negedge clk);
    idle();
    model[16] = 32'h0000_0DD0;
    ld_issue = 1; ld_postinc = 1; ld_base_idx = 5'd4; ld_dst_idx = 5'd4;
    @(negedge clk);
    idle();
    mem_rvalid = 1; mem_rdata = 32'h0000_0400;
    res_we = 1; res_idx = 5'd4; res_data = 32'h0000_2000;
    @(negedge clk);
    idle();
    model[4] = 32'h0000_0400;
    rd_a("R9 load data wins over delayed address", 4);
    rd_b("R9 load data on port B", 4);

    // R11: the entry is retired, a later write is ordinary
    @(negedge clk);
    res_we = 1; res_idx = 5'd4; res_data = 32'h0000_0055;
    @(negedge clk);
    idle();
    model[4] = 32'h0000_0055;
    rd_a("R11 write after retire", 4);

    // R5: stray response with nothing pending changes no register
    @(negedge clk);
    mem_rvalid = 1; mem_rdata = 32'hDEAD_BEEF;
    @(negedge clk);
    idle();
    for (int i = 0; i < 32; i++) rd_b("R5 stray response ignored", i);

    // R3: load aimed at index 0 is discarded
    @(negedge clk);
    ld_issue = 1; ld_postinc = 0; ld_base_idx = 5'd3; ld_dst_idx = 5'd0;
    @(negedge clk);
    idle();
    mem_rvalid = 1; mem_rdata = 32'h0BAD_0BAD;
    @(negedge clk);
    idle();
    rd_a("R3 load to index 0", 0);

    // R10: floating-point result lands in the integer register
    @(negedge clk);
    res_we = 1; res_fp = 1; res_idx = 5'd12; res_data = 32'h3F80_0000;
    @(negedge clk);
    idle();
    model[12] = 32'h3F80_0000;
    rd_a("R10 fp result in integer register", 12);

    done = 1'b1;
    summary();
  end

endmodule